// File: doc/BRIEF.md
# Wear-Driven Flash Page Refresh Scheduler

This block sits on the host side of a serial flash with 1024 pages. Under random-write workloads, every page has to be rewritten within a bounded number of cumulative erase/program operations to keep its data intact. The block counts the erase/program operations that the user write path reports. Once that count reaches a threshold, it refreshes one page. It takes the next page from a rolling pointer, so every page is revisited within a bounded number of operations. The refresh is the flash's built-in rewrite command, which reads the page into an on-chip buffer and programs it back.

The block shares a serial command port with other users. It raises a request and waits for the grant. It then polls the status register until the ready bit is set, sends the rewrite frame, and polls again until the array is idle. Only then does it release the port. While a refresh is due or in progress, the block holds off the next user program.

Top module: `rfsh_scheduler`

## Requirements
- R1: Each cycle with `user_op_done` high counts one user operation. When the count reaches `REFRESH_EVERY`, a refresh becomes due. `user_hold` is high from the clock edge that registers that operation.
- R2: `port_req` rises on the clock edge after a refresh becomes due while the block is idle. It stays high until the refresh is fully complete.
- R3: `xfer_start` is never high unless `port_gnt` is high. While the grant is withheld, no transfer starts.
- R4: Before the rewrite frame, the block issues status-read transfers (`xfer_is_status`=1, `xfer_cmd`=0x57000000). It repeats them until a transfer completes with `xfer_stat_rdy`=1, meaning bit 7 of the status byte is 1.
- R5: The rewrite transfer has `xfer_is_status`=0. Its `xfer_cmd` is {opcode, 5 zero bits, the 10-bit page number, 9 zero bits}, with the opcode 0x58 when `USE_BUF2`=0 and 0x59 when `USE_BUF2`=1.
- R6: After the rewrite transfer completes, the block issues status reads until one returns ready. `port_req` falls on the edge that registers that ready completion.
- R7: The page pointer starts at 0 after reset. It advances by one after each completed refresh and wraps from 1023 to 0. The first rewrite after reset targets page 0.
- R8: Refresh transfers do not count as user operations. User operations reported while a refresh is in progress count toward the next interval. The count saturates at `REFRESH_EVERY`. The edge that starts a refresh clears the count to 0, or to 1 if an operation is reported in that same cycle.
- R9: `user_hold` is high whenever a refresh is due or in progress, and low otherwise.
- R10: At most one transfer is outstanding. After `xfer_start`, no new start occurs until `xfer_done` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_op_done | input | 1 | One-cycle pulse per user erase/program operation issued |
| user_hold | output | 1 | Blocks the next user program while a refresh is due or running |
| port_req | output | 1 | Request for the shared command port |
| port_gnt | input | 1 | Grant of the shared command port |
| xfer_start | output | 1 | One-cycle pulse launching a transfer on the port |
| xfer_is_status | output | 1 | 1: status read (opcode byte, then one byte returned); 0: 32-bit command |
| xfer_cmd | output | 32 | Frame bits, most significant bit sent first |
| xfer_done | input | 1 | One-cycle pulse when the transfer ends |
| xfer_stat_rdy | input | 1 | Bit 7 of the returned status byte, valid with `xfer_done` |

## Verification
A user operation seen at a rising edge raises `user_hold` from that same edge when it completes the interval. `port_req` follows one edge later. Each transfer start appears in the cycle after the grant or done that enables it is registered. A completion that returns ready moves the block on at that edge, and the advanced pointer shows in the next rewrite frame. The bench drives every input at the falling edge. A behavioural model advances on the rising edge using the same sampled inputs, and all outputs are compared against it at the following falling edge. This way each result is checked in exactly the cycle it is due. Each captured rewrite frame is also checked against the page sequence, with its wrap past page 1023.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_PRE_GO, ST_PRE_WT,
    ST_RW_GO, ST_RW_WT, ST_POST_GO, ST_POST_WT
  } rfsh_state_e;

  localparam logic [7:0] OPC_STATUS  = 8'h57;
  localparam logic [7:0] OPC_REWR_B1 = 8'h58;
  localparam logic [7:0] OPC_REWR_B2 = 8'h59;
  localparam int         FRAME_W     = 32;
  localparam int         ADDR_W      = 24;
  localparam int         TAIL_W      = 9;
endpackage

// File: rtl/rfsh_op_counter.sv
module rfsh_op_counter #(
  parameter int LIMIT = 9,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic op_pulse,
  input  logic clear,
  output logic due
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign due = (cnt_q == CNT_W'(LIMIT));

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clear) begin
      cnt_en = 1'b1;
      cnt_d  = op_pulse ? CNT_W'(1) : '0;
    end else if (op_pulse && !due) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8: the count never passes the threshold
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LIMIT));
  // R1: an operation below the threshold adds exactly one
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pulse && !clear && !due) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/rfsh_page_ptr.sv
module rfsh_page_ptr #(
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [PAGE_W-1:0] page
);
  logic [PAGE_W-1:0] page_d;

  always_comb page_d = page + PAGE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   page <= '0;
    else if (adv) page <= page_d;
  end

  // R7: one step per completed refresh, natural wrap at the top page
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (page == PAGE_W'($past(page) + PAGE_W'(1))));
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(page));
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic due,
  input  logic gnt,
  input  logic done,
  input  logic stat_rdy,
  output logic launch,
  output logic advance,
  output logic busy,
  output logic port_req,
  output logic start,
  output logic is_status
);
  rfsh_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (due) st_d = ST_REQ;
      ST_REQ:     if (gnt) st_d = ST_PRE_GO;
      ST_PRE_GO:  st_d = ST_PRE_WT;
      ST_PRE_WT:  if (done) st_d = stat_rdy ? ST_RW_GO : ST_PRE_GO;
      ST_RW_GO:   st_d = ST_RW_WT;
      ST_RW_WT:   if (done) st_d = ST_POST_GO;
      ST_POST_GO: st_d = ST_POST_WT;
      ST_POST_WT: if (done) st_d = stat_rdy ? ST_IDLE : ST_POST_GO;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign launch    = (st_q == ST_IDLE) && due;
  assign advance   = (st_q == ST_POST_WT) && done && stat_rdy;
  assign busy      = (st_q != ST_IDLE);
  assign port_req  = busy;
  assign start     = (st_q == ST_PRE_GO) || (st_q == ST_RW_GO) ||
                     (st_q == ST_POST_GO);
  assign is_status = (st_q != ST_RW_GO);

  // R3: a transfer only starts while the port is granted
  assert_start_gnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> gnt);
  // R10: a start is followed by a wait, never by a back-to-back start
  assert_one_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  // R6: the port is released only after a ready completion
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(port_req) |-> $past(done && stat_rdy));
  // R4: the rewrite is launched only after a ready status reply
  assert_pre_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !is_status) |-> $past(done && stat_rdy));
endmodule

// File: rtl/rfsh_scheduler.sv
module rfsh_scheduler
  import rfsh_pkg::*;
#(
  parameter int REFRESH_EVERY = 9,
  parameter int PAGE_W        = 10,
  parameter bit USE_BUF2      = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               user_op_done,
  output logic               user_hold,
  output logic               port_req,
  input  logic               port_gnt,
  output logic               xfer_start,
  output logic               xfer_is_status,
  output logic [FRAME_W-1:0] xfer_cmd,
  input  logic               xfer_done,
  input  logic               xfer_stat_rdy
);
  localparam int         RSV_W     = ADDR_W - TAIL_W - PAGE_W;
  localparam logic [7:0] OPC_REWR  = USE_BUF2 ? OPC_REWR_B2 : OPC_REWR_B1;

  logic              due, launch, advance, busy;
  logic [PAGE_W-1:0] page;

  rfsh_op_counter #(.LIMIT(REFRESH_EVERY)) u_cnt (
    .clk(clk), .rst_n(rst_n), .op_pulse(user_op_done),
    .clear(launch), .due(due)
  );

  rfsh_page_ptr #(.PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(advance), .page(page)
  );

  rfsh_seq u_seq (
    .clk(clk), .rst_n(rst_n), .due(due), .gnt(port_gnt),
    .done(xfer_done), .stat_rdy(xfer_stat_rdy),
    .launch(launch), .advance(advance), .busy(busy),
    .port_req(port_req), .start(xfer_start), .is_status(xfer_is_status)
  );

  assign user_hold = due || busy;

  generate
    if (RSV_W > 0) begin : g_rsv
      always_comb
        xfer_cmd = xfer_is_status ? {OPC_STATUS, {ADDR_W{1'b0}}}
                                  : {OPC_REWR, {RSV_W{1'b0}}, page, {TAIL_W{1'b0}}};
    end else begin : g_norsv
      always_comb
        xfer_cmd = xfer_is_status ? {OPC_STATUS, {ADDR_W{1'b0}}}
                                  : {OPC_REWR, page, {TAIL_W{1'b0}}};
    end
  endgenerate

  // R9: a new port request is only made after the hold was already raised
  assert_hold_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_req) |-> $past(user_hold));
  // R2: while requesting, the hold to the user path stays up
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    port_req |-> user_hold);
endmodule

// File: tb/test_rfsh_scheduler.sv
`timescale 1ns/1ps
module test_rfsh_scheduler;
  localparam int TH     = 9;
  localparam int NPAGES = 1024;
  localparam int TARGET = 1030;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        user_op_done;
  logic        user_hold, port_req, port_gnt;
  logic        xfer_start, xfer_is_status, xfer_done, xfer_stat_rdy;
  logic [31:0] xfer_cmd;

  always #4 clk = ~clk;

  rfsh_scheduler #(.REFRESH_EVERY(TH), .PAGE_W(10), .USE_BUF2(1'b0)) i_rfsh_scheduler (
    .clk(clk), .rst_n(rst_n), .user_op_done(user_op_done), .user_hold(user_hold),
    .port_req(port_req), .port_gnt(port_gnt), .xfer_start(xfer_start),
    .xfer_is_status(xfer_is_status), .xfer_cmd(xfer_cmd),
    .xfer_done(xfer_done), .xfer_stat_rdy(xfer_stat_rdy)
  );

  int vectors = 0, fails = 0, cycles = 0, nref = 0, npolls = 0;

  // behavioural reference: protocol phase, op count, page pointer
  int m_ph = 0, m_cnt = 0, m_page = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_page = 0;
    end else begin
      bit starting;
      starting = (m_ph == 0) && (m_cnt == TH);
      case (m_ph)
        0: if (starting) m_ph = 1;                 // waiting for the port
        1: if (port_gnt) m_ph = 2;
        2: m_ph = 3;                               // pre-poll issued
        3: if (xfer_done) m_ph = xfer_stat_rdy ? 4 : 2;
        4: m_ph = 5;                               // rewrite issued
        5: if (xfer_done) m_ph = 6;
        6: m_ph = 7;                               // post-poll issued
        7: if (xfer_done) begin
             if (xfer_stat_rdy) begin m_ph = 0; m_page = (m_page + 1) % NPAGES; end
             else m_ph = 6;
           end
        default: m_ph = 0;
      endcase
      if (starting) m_cnt = user_op_done ? 1 : 0;
      else if (user_op_done && m_cnt < TH) m_cnt = m_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // environment: arbiter and serial master, plus comparison, all at falling edge
  int other_cnt = 0, lat = 0, busy_left = 0;
  bit lat_status = 1'b0, prev_req = 1'b0;
  always @(negedge clk) begin
    bit e_start;
    logic [31:0] e_cmd;
    cycles++;
    e_start = (m_ph == 2) || (m_ph == 4) || (m_ph == 6);
    e_cmd   = (m_ph == 4) ? {8'h58, 5'b0, 10'(m_page), 9'b0} : {8'h57, 24'h0};
    chk("R1 R8 R9 user_hold", 32'(user_hold), 32'((m_ph != 0) || (m_cnt == TH)));
    chk("R2 R6 port_req", 32'(port_req), 32'(m_ph != 0));
    chk("R3 R10 xfer_start", 32'(xfer_start), 32'(e_start));
    if (e_start) begin
      chk("R4 R5 xfer_is_status", 32'(xfer_is_status), 32'(m_ph != 4));
      chk("R4 R5 R7 xfer_cmd", xfer_cmd, e_cmd);
    end
    if (rst_n) begin
      // arbiter, sometimes busy with another user
      if (port_req && !prev_req) begin
        other_cnt = (nref % 5 == 0) ? 4 : 0;
        busy_left = nref % 3;
      end
      prev_req = port_req;
      if (other_cnt > 0) begin other_cnt--; port_gnt = 1'b0; end
      else port_gnt = port_req;
      // serial master
      xfer_done = 1'b0; xfer_stat_rdy = 1'b0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          xfer_done = 1'b1;
          if (lat_status) begin
            npolls++;
            if (busy_left > 0) busy_left--; else xfer_stat_rdy = 1'b1;
          end
        end
      end
      if (xfer_start) begin
        lat = 3; lat_status = xfer_is_status;
        if (!xfer_is_status) begin
          // R5 R7: frames target consecutive pages, wrapping after 1023
          chk("R5 R7 rewrite frame", xfer_cmd, {8'h58, 5'b0, 10'(nref % NPAGES), 9'b0});
          nref++;
          busy_left = (nref % 4) + 1;
        end
      end
    end
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; user_op_done = 1'b0; port_gnt = 1'b0;
    xfer_done = 1'b0; xfer_stat_rdy = 1'b0;
    repeat (3) @(negedge clk);
    // reset state: R1 R2 R9 outputs quiet
    chk("R1 reset user_hold", 32'(user_hold), 32'h0);
    chk("R2 reset port_req", 32'(port_req), 32'h0);
    chk("R3 reset xfer_start", 32'(xfer_start), 32'h0);
    rst_n = 1'b1;
    while (nref < TARGET) begin
      @(negedge clk);
      // R8: every seventh interval keeps reporting ops during the refresh
      user_op_done = (($urandom % 3) == 0) && ((nref % 7 == 3) || !user_hold);
    end
    user_op_done = 1'b0;
    repeat (60) @(negedge clk);
    chk("R4 R6 status polls issued", 32'(npolls >= 2 * TARGET), 32'h1);
    chk("R7 refresh count", 32'(nref >= TARGET), 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule